// File: doc/BRIEF.md
# Shared CPU/DMA Buffer Memory with CPU-First Collision Resolution

This block is a true two-port word memory that sits at the top end of a larger data address map. One port serves the processor and the other serves a DMA engine. Both ports can read and write any word of the buffer in the same clock cycle. Neither port ever waits for the other, so DMA traffic takes no cycles from the processor. When no DMA traffic is present, the processor can use the region as ordinary storage.

Each port presents a full byte address. The port decodes that address against the region window and raises its hit output when the address falls inside. The window is the last `BUF_BYTES` bytes of the upper data region, or of the lower region when the build has no upper region. Words are 16 bits wide and each port has a byte-lane enable.

If both ports write the same word in one cycle, the processor's lanes are stored. The DMA write keeps only the lanes that the processor left alone. The DMA side then receives a one-cycle collision pulse so that it can retry the write.

Top module: `dma_share_ram`

## Requirements
- R1: `cpu_hit_o` / `dma_hit_o` are combinational and high exactly when the port's byte address lies in [BASE, LIMIT]. LIMIT is `Y_END_ADDR` when `HAS_Y_SPACE`=1 and `X_END_ADDR` otherwise, and BASE = LIMIT - `BUF_BYTES` + 1.
- R2: A write whose address misses the window changes no stored word.
- R3: A hit write stores lane 0 (data bits 7:0) when enable bit 0 is set and lane 1 (data bits 15:8) when enable bit 1 is set. Any lane that is not enabled keeps its value. The word index is (address - BASE) >> 1, so address bit 0 is ignored.
- R4: The read data of a port appears in the cycle after the address is presented. It is the word's content from before that edge's writes, from either port. After a miss the read data is 0.
- R5: Both ports can write different words in the same cycle, and both writes take effect.
- R6: If both ports write the same word in one cycle, the processor's enabled lanes take the processor's data. The DMA's enabled lanes that the processor did not write take the DMA's data.
- R7: `dma_collide_o` is high for exactly the cycle after an edge at which both ports hit and wrote the same word with at least one common lane. Otherwise it is low.
- R8: A processor write always takes effect, whatever the DMA port does in that cycle.
- R9: While `rst_ni` is low, both read data outputs and `dma_collide_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_addr_i | input | ADDR_W | Processor byte address |
| cpu_we_i | input | 1 | Processor write |
| cpu_be_i | input | DATA_W/8 | Processor byte-lane enables |
| cpu_wdata_i | input | DATA_W | Processor write data |
| cpu_rdata_o | output | DATA_W | Processor read data, one cycle later |
| cpu_hit_o | output | 1 | Processor address inside window |
| dma_addr_i | input | ADDR_W | DMA byte address |
| dma_we_i | input | 1 | DMA write |
| dma_be_i | input | DATA_W/8 | DMA byte-lane enables |
| dma_wdata_i | input | DATA_W | DMA write data |
| dma_rdata_o | output | DATA_W | DMA read data, one cycle later |
| dma_hit_o | output | 1 | DMA address inside window |
| dma_collide_o | output | 1 | DMA write lost lanes to processor (pulse) |

## Verification
The main instance is built with a 12-bit address, a 64-byte buffer and the upper region ending at 0xBFF. This puts the window at 0xBC0 to 0xBFF, so all 32 words, both window edges and the addresses just outside them can be reached in a short run. A second instance is built with `HAS_Y_SPACE`=0 and the lower region ending at 0x7FF, which checks that the window moves to 0x7C0 to 0x7FF. With so few words, random traffic near the window often puts both ports on the same word, which exercises the collision rules repeatedly.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic int unsigned window_base(input int unsigned last_byte,
                                              input int unsigned size_bytes);
    return last_byte - size_bytes + 1;
  endfunction
endpackage

// File: rtl/dsr_decode.sv
module dsr_decode #(
  parameter int unsigned      ADDR_W = 16,
  parameter int unsigned      IDX_W  = 11,
  parameter int unsigned      LSB    = 1,
  parameter logic [ADDR_W-1:0] BASE_A = '0,
  parameter logic [ADDR_W-1:0] LIMIT_A = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  assign hit_o = (addr_i >= BASE_A) && (addr_i <= LIMIT_A);
  assign idx_o = IDX_W'((addr_i - BASE_A) >> LSB);
endmodule

// File: rtl/dsr_lane_arb.sv
module dsr_lane_arb #(
  parameter int unsigned LANES = 2,
  parameter int unsigned IDX_W = 11
) (
  input  logic             c_wr_i,
  input  logic             d_wr_i,
  input  logic [LANES-1:0] c_be_i,
  input  logic [LANES-1:0] d_be_i,
  input  logic [IDX_W-1:0] c_idx_i,
  input  logic [IDX_W-1:0] d_idx_i,
  output logic [LANES-1:0] c_lane_o,
  output logic [LANES-1:0] d_lane_o,
  output logic             lost_o
);
  logic same_word;

  always_comb begin
    same_word = c_wr_i && d_wr_i && (c_idx_i == d_idx_i);
    c_lane_o  = c_wr_i ? c_be_i : '0;
    // processor lanes mask the DMA lanes on a shared word
    d_lane_o  = d_wr_i ? (d_be_i & ~(same_word ? c_be_i : '0)) : '0;
    lost_o    = same_word && |(c_be_i & d_be_i);
  end
endmodule

// File: rtl/dsr_mem.sv
module dsr_mem #(
  parameter int unsigned LANES = 2,
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned IDX_W = 11,
  localparam int unsigned DATA_W = LANES * dsr_pkg::LANE_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  c_idx_i,
  input  logic [LANES-1:0]  c_lane_i,
  input  logic [DATA_W-1:0] c_wdata_i,
  output logic [DATA_W-1:0] c_q_o,
  input  logic [IDX_W-1:0]  d_idx_i,
  input  logic [LANES-1:0]  d_lane_i,
  input  logic [DATA_W-1:0] d_wdata_i,
  output logic [DATA_W-1:0] d_q_o
);
  localparam int unsigned LW = dsr_pkg::LANE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] store [DEPTH];
    logic [LW-1:0] c_q_l, d_q_l;

    // read-first: both ports see contents from before this edge
    always_ff @(posedge clk_i) begin
      c_q_l <= store[c_idx_i];
      d_q_l <= store[d_idx_i];
      if (d_lane_i[l]) store[d_idx_i] <= d_wdata_i[l*LW +: LW];
      if (c_lane_i[l]) store[c_idx_i] <= c_wdata_i[l*LW +: LW];
    end

    assign c_q_o[l*LW +: LW] = c_q_l;
    assign d_q_o[l*LW +: LW] = d_q_l;
  end
endmodule

// File: rtl/dma_share_ram.sv
module dma_share_ram #(
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned BUF_BYTES   = 4096,
  parameter bit          HAS_Y_SPACE = 1'b1,
  parameter int unsigned X_END_ADDR  = 'h7FFF,
  parameter int unsigned Y_END_ADDR  = 'hBFFF,
  localparam int unsigned LANES = DATA_W / dsr_pkg::LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              cpu_we_i,
  input  logic [LANES-1:0]  cpu_be_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_hit_o,
  input  logic [ADDR_W-1:0] dma_addr_i,
  input  logic              dma_we_i,
  input  logic [LANES-1:0]  dma_be_i,
  input  logic [DATA_W-1:0] dma_wdata_i,
  output logic [DATA_W-1:0] dma_rdata_o,
  output logic              dma_hit_o,
  output logic              dma_collide_o
);
  localparam int unsigned DEPTH    = BUF_BYTES / LANES;
  localparam int unsigned IDX_W    = $clog2(DEPTH);
  localparam int unsigned LSB      = $clog2(LANES);
  localparam int unsigned LAST_B   = HAS_Y_SPACE ? Y_END_ADDR : X_END_ADDR;
  localparam int unsigned BASE_B   = dsr_pkg::window_base(LAST_B, BUF_BYTES);
  localparam logic [ADDR_W-1:0] BASE_A  = BASE_B[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] LIMIT_A = LAST_B[ADDR_W-1:0];

  logic [1:0][ADDR_W-1:0] addr_a;
  logic [1:0]             hit_a;
  logic [1:0][IDX_W-1:0]  idx_a;

  assign addr_a[0] = cpu_addr_i;
  assign addr_a[1] = dma_addr_i;

  for (genvar p = 0; p < 2; p++) begin : g_port
    dsr_decode #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .LSB    (LSB),
      .BASE_A (BASE_A),
      .LIMIT_A(LIMIT_A)
    ) u_dec (
      .addr_i(addr_a[p]),
      .hit_o (hit_a[p]),
      .idx_o (idx_a[p])
    );
  end

  assign cpu_hit_o = hit_a[0];
  assign dma_hit_o = hit_a[1];

  logic [LANES-1:0] c_lane, d_lane;
  logic             lost;

  dsr_lane_arb #(.LANES(LANES), .IDX_W(IDX_W)) u_arb (
    .c_wr_i  (cpu_we_i && hit_a[0]),
    .d_wr_i  (dma_we_i && hit_a[1]),
    .c_be_i  (cpu_be_i),
    .d_be_i  (dma_be_i),
    .c_idx_i (idx_a[0]),
    .d_idx_i (idx_a[1]),
    .c_lane_o(c_lane),
    .d_lane_o(d_lane),
    .lost_o  (lost)
  );

  logic [DATA_W-1:0] c_q, d_q;

  dsr_mem #(.LANES(LANES), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
    .clk_i    (clk_i),
    .c_idx_i  (idx_a[0]),
    .c_lane_i (c_lane),
    .c_wdata_i(cpu_wdata_i),
    .c_q_o    (c_q),
    .d_idx_i  (idx_a[1]),
    .d_lane_i (d_lane),
    .d_wdata_i(dma_wdata_i),
    .d_q_o    (d_q)
  );

  logic cpu_rv, dma_rv, collide_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_rv    <= 1'b0;
      dma_rv    <= 1'b0;
      collide_q <= 1'b0;
    end else begin
      cpu_rv    <= hit_a[0];
      dma_rv    <= hit_a[1];
      collide_q <= lost;
    end
  end

  assign cpu_rdata_o   = cpu_rv ? c_q : '0;
  assign dma_rdata_o   = dma_rv ? d_q : '0;
  assign dma_collide_o = collide_q;
endmodule

// File: rtl/dma_share_ram_chk.sv
module dma_share_ram_chk #(
  parameter int unsigned       ADDR_W  = 16,
  parameter int unsigned       DATA_W  = 16,
  parameter int unsigned       LSB     = 1,
  parameter logic [ADDR_W-1:0] BASE_A  = '0,
  parameter logic [ADDR_W-1:0] LIMIT_A = '1,
  localparam int unsigned LANES = DATA_W / 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic              cpu_we_i,
  input logic [LANES-1:0]  cpu_be_i,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              cpu_hit_o,
  input logic [ADDR_W-1:0] dma_addr_i,
  input logic              dma_we_i,
  input logic [LANES-1:0]  dma_be_i,
  input logic [DATA_W-1:0] dma_rdata_o,
  input logic              dma_hit_o,
  input logic              dma_collide_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  logic same_word, overlap;
  assign same_word = (cpu_addr_i >> LSB) == (dma_addr_i >> LSB);
  assign overlap   = |(cpu_be_i & dma_be_i);

  AST_CPU_HIT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o == ((cpu_addr_i >= BASE_A) && (cpu_addr_i <= LIMIT_A))); // R1
  AST_DMA_HIT_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_hit_o == ((dma_addr_i >= BASE_A) && (dma_addr_i <= LIMIT_A))); // R1
  AST_CPU_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(cpu_hit_o) |-> cpu_rdata_o == '0); // R4
  AST_DMA_MISS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !$past(dma_hit_o) |-> dma_rdata_o == '0); // R4
  AST_COLLIDE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && dma_collide_o |->
      $past(cpu_we_i && dma_we_i && cpu_hit_o && dma_hit_o && same_word && overlap)); // R7
  AST_COLLIDE_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_we_i && dma_we_i && cpu_hit_o && dma_hit_o && same_word && overlap
      |=> dma_collide_o); // R7

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (cpu_rdata_o == '0 && dma_rdata_o == '0 && !dma_collide_o); // R9
    end
  end
endmodule

bind dma_share_ram dma_share_ram_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .LSB    (LSB),
  .BASE_A (BASE_A),
  .LIMIT_A(LIMIT_A)
) u_chk (.*);

// File: tb/tb_dma_share_ram.sv
`timescale 1ns/1ps
module tb_dma_share_ram;
  localparam int AW = 12;
  localparam logic [11:0] YB = 12'hBC0, YL = 12'hBFF;
  localparam logic [11:0] XB = 12'h7C0, XL = 12'h7FF;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #2.5 clk = ~clk;

  logic [11:0] ca, da;
  logic        cw, dw;
  logic [1:0]  cbe, dbe;
  logic [15:0] cd, dd;
  logic [15:0] c_rd, d_rd, xc_rd, xd_rd;
  logic        c_hit, d_hit, col, xc_hit, xd_hit, xcol;

  dma_share_ram #(.ADDR_W(AW), .DATA_W(16), .BUF_BYTES(64), .HAS_Y_SPACE(1'b1),
                  .X_END_ADDR('h7FF), .Y_END_ADDR('hBFF)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_addr_i(ca), .cpu_we_i(cw), .cpu_be_i(cbe), .cpu_wdata_i(cd),
    .cpu_rdata_o(c_rd), .cpu_hit_o(c_hit),
    .dma_addr_i(da), .dma_we_i(dw), .dma_be_i(dbe), .dma_wdata_i(dd),
    .dma_rdata_o(d_rd), .dma_hit_o(d_hit), .dma_collide_o(col));

  dma_share_ram #(.ADDR_W(AW), .DATA_W(16), .BUF_BYTES(64), .HAS_Y_SPACE(1'b0),
                  .X_END_ADDR('h7FF), .Y_END_ADDR('hBFF)) dut_x (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_addr_i(ca), .cpu_we_i(1'b0), .cpu_be_i(cbe), .cpu_wdata_i(cd),
    .cpu_rdata_o(xc_rd), .cpu_hit_o(xc_hit),
    .dma_addr_i(da), .dma_we_i(1'b0), .dma_be_i(dbe), .dma_wdata_i(dd),
    .dma_rdata_o(xd_rd), .dma_hit_o(xd_hit), .dma_collide_o(xcol));

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] mdl [32];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic bit in_win(input logic [11:0] a, input logic [11:0] b, input logic [11:0] l);
    return (a >= b) && (a <= l);
  endfunction

  task automatic step(input logic w0, input logic [1:0] be0, input logic [11:0] a0, input logic [15:0] d0,
                      input logic w1, input logic [1:0] be1, input logic [11:0] a1, input logic [15:0] d1,
                      input string tag);
    bit hc, hd, same, ecol;
    logic [4:0] ci, di;
    logic [15:0] ecr, edr;
    ca = a0; cw = w0; cbe = be0; cd = d0;
    da = a1; dw = w1; dbe = be1; dd = d1;
    #1;
    hc = in_win(a0, YB, YL);
    hd = in_win(a1, YB, YL);
    check(c_hit === hc, "R1", "cpu hit", c_hit, hc);
    check(d_hit === hd, "R1", "dma hit", d_hit, hd);
    check(xc_hit === in_win(a0, XB, XL), "R1", "x-build cpu hit", xc_hit, in_win(a0, XB, XL));
    check(xd_hit === in_win(a1, XB, XL), "R1", "x-build dma hit", xd_hit, in_win(a1, XB, XL));
    ci = 5'((a0 - YB) >> 1);
    di = 5'((a1 - YB) >> 1);
    ecr = hc ? mdl[ci] : 16'h0;
    edr = hd ? mdl[di] : 16'h0;
    same = w0 && w1 && hc && hd && (ci == di);
    ecol = same && |(be0 & be1);
    if (w1 && hd) for (int l = 0; l < 2; l++)
      if (be1[l] && !(same && be0[l])) mdl[di][l*8 +: 8] = d1[l*8 +: 8];
    if (w0 && hc) for (int l = 0; l < 2; l++)
      if (be0[l]) mdl[ci][l*8 +: 8] = d0[l*8 +: 8];
    @(posedge clk); #1;
    if (!$isunknown(ecr)) check(c_rd === ecr, tag, "cpu rdata (R4)", c_rd, ecr);
    if (!$isunknown(edr)) check(d_rd === edr, tag, "dma rdata (R4)", d_rd, edr);
    check(col === ecol, "R7", "dma collide", col, ecol);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 2'b00, 12'h000, 16'h0, 0, 2'b00, 12'h000, 16'h0, tag);
  endtask

  task automatic rd(input logic [11:0] a0, input logic [11:0] a1, input string tag);
    step(0, 2'b00, a0, 16'h0, 0, 2'b00, a1, 16'h0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = 'x;
    ca = '0; da = '0; cw = 0; dw = 0; cbe = '0; dbe = '0; cd = '0; dd = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check(c_rd === 16'h0, "R9", "cpu rdata in reset", c_rd, 16'h0);
    check(d_rd === 16'h0, "R9", "dma rdata in reset", d_rd, 16'h0);
    check(col === 1'b0, "R9", "collide in reset", col, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // fill: processor writes every word, DMA idle out of window (R8 general storage)
    for (int w = 0; w < 32; w++)
      step(1, 2'b11, YB + 12'(2*w), 16'hA000 + 16'(w), 0, 2'b00, 12'h000, 16'h0, "R8");
    for (int w = 0; w < 32; w++)
      rd(YB + 12'(2*w), YB + 12'(62 - 2*w), "R8");

    // R2: writes outside the window
    step(1, 2'b11, YB - 12'd2, 16'hDEAD, 1, 2'b11, YL + 12'd1, 16'hBEEF, "R2");
    step(1, 2'b11, YB - 12'd1, 16'hDEAD, 1, 2'b11, 12'h000, 16'hBEEF, "R2");
    rd(YB, YL, "R2");

    // R3: byte lanes and ignored address bit 0
    step(1, 2'b01, YB + 12'd5, 16'h1234, 1, 2'b10, YB + 12'd8, 16'h5678, "R3");
    rd(YB + 12'd4, YB + 12'd9, "R3");
    step(1, 2'b10, YB + 12'd4, 16'h9A00, 0, 2'b00, YB + 12'd4, 16'h0, "R3");
    rd(YB + 12'd5, YB + 12'd4, "R3");

    // R5: parallel writes to different words
    step(1, 2'b11, YB + 12'd10, 16'h1111, 1, 2'b11, YB + 12'd12, 16'h2222, "R5");
    rd(YB + 12'd12, YB + 12'd10, "R5");

    // R6/R8: same word, full overlap; then partial overlap; then disjoint lanes
    step(1, 2'b11, YB + 12'd20, 16'hC0C0, 1, 2'b11, YB + 12'd21, 16'hD0D0, "R6");
    rd(YB + 12'd20, YB + 12'd20, "R8");
    step(1, 2'b01, YB + 12'd20, 16'h00AA, 1, 2'b11, YB + 12'd20, 16'hBBCC, "R6");
    rd(YB + 12'd20, YB + 12'd20, "R6");
    step(1, 2'b01, YB + 12'd22, 16'h0011, 1, 2'b10, YB + 12'd22, 16'h2200, "R6");
    rd(YB + 12'd22, YB + 12'd22, "R6");

    // R4: read-first across ports on the same word
    step(0, 2'b00, YB + 12'd30, 16'h0, 1, 2'b11, YB + 12'd30, 16'h7777, "R4");
    step(1, 2'b11, YB + 12'd30, 16'h8888, 0, 2'b00, YB + 12'd30, 16'h0, "R4");
    rd(YB + 12'd30, YB - 12'd2, "R4");

    // R1: window edges
    rd(YB, YL, "R1");
    rd(YL + 12'd1, YB - 12'd1, "R1");
    rd(XB, XL, "R1");
    rd(XB - 12'd1, XL + 12'd1, "R1");

    // random traffic around the window
    for (int k = 0; k < 400; k++) begin
      logic [11:0] a0, a1;
      a0 = YB - 12'd8 + 12'($urandom % 80);
      a1 = ($urandom % 3 == 0) ? a0 : (YB - 12'd8 + 12'($urandom % 80));
      step(1'($urandom), 2'($urandom), a0, 16'($urandom),
           1'($urandom), 2'($urandom), a1, 16'($urandom), "R6");
    end
    for (int w = 0; w < 32; w++)
      rd(YB + 12'(2*w), YB + 12'(2*w), "R8");

    idle("R4");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule